// File: doc/BRIEF.md
# Column Serial Readout Chain with Hit Compression

This block moves the records captured by a matrix of pixel channels off the chip, one column at a time. Inside a column every channel holds one 22-bit record: a hit flag, an 8-bit arrival time, a 5-bit energy (time over threshold) and an 8-bit map of which subpixels fired. During readout the channels of the active column are linked into a single serial shift chain that runs at the readout clock, nominally 40 MHz. The channel nearest the output comes first and the farthest comes last.

An optional compression mode shortens the chain. With compression on, a channel whose hit flag is clear contributes only that flag bit, and its other 21 bits are bypassed. A channel with a hit always sends its full record. A frame-valid output brackets the whole transfer over all columns. A forwarded sample clock gives the acquisition system one rising edge in the middle of every data bit. A one-hot column select shows which column is currently being clocked.

A readout is started by a single-cycle request. The compression choice is captured at that moment. Each column's records are loaded in parallel on the cycle that column's transfer begins. The next column is loaded on the same edge that retires the last bit of the previous one, so the stream has no gaps.

Top module: `colro_chain_top`

## Requirements
- R1: After reset, and whenever no frame is in progress, `frame_o` is 0, `sdo_o` is 0, `col_sel_o` is all zero and `smp_clk_o` stays low.
- R2: A `start_i` sampled high while idle raises `frame_o` on the next cycle. In that cycle `sdo_o` carries the hit flag of channel 0 of column 0.
- R3: Each record that is sent in full leaves MSB first from a 22-bit word. Bit 21 is the hit flag, bits 20..13 are the arrival time, bits 12..8 are the energy and bits 7..0 are the subpixel map. Channels leave in increasing index order (index 0 is nearest the output). Columns leave in increasing index order. Channel `ch` of column `c` occupies bits `(c*NCH+ch)*22 +: 22` of `rec_i`.
- R4: With compression off, every channel sends all 22 bits regardless of its flag. A frame then lasts exactly NCOL*NCH*22 cycles.
- R5: With compression on, a channel whose bit 21 is 0 sends a single 0 bit and its remaining 21 bits never appear on `sdo_o`. A channel whose bit 21 is 1 sends all 22 bits.
- R6: While `frame_o` is high, `col_sel_o` has exactly the bit of the column whose data is on `sdo_o` set. It steps from column c to column c+1 with no idle cycle between columns.
- R7: `frame_o` stays high for exactly the number of bits in the frame. It falls after the last bit of the last column.
- R8: `smp_clk_o` gives exactly one rising edge per transmitted bit. Each edge falls on the falling edge of `clk_i`, in the middle of the bit. There are no edges outside the frame.
- R9: Changes of `comp_en_i` and further `start_i` pulses while a frame is in progress have no effect on the stream or its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Readout clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Readout request, sampled only while idle |
| comp_en_i | input | 1 | Compression enable, captured with the request |
| rec_i | input | NCOL*NCH*22 | Channel records of the whole matrix |
| sdo_o | output | 1 | Serial data out |
| frame_o | output | 1 | High while frame bits are transmitted |
| smp_clk_o | output | 1 | Forwarded sample clock, rising mid-bit |
| col_sel_o | output | NCOL | One-hot select of the column being clocked |

## Verification
The assertions check several rules on every cycle. The column select only ever steps to the next column, a bypassed channel keeps its skipped bits frozen while the chain shifts, the bit counter stays within one column's capacity, the captured compression mode holds for the whole frame, and the frame ends only on the final bit of the final column. Whether the right bits come out in the right order cannot be seen from any single cycle. The same holds for skipping exactly the 21 bits of empty channels, frame length and sample-clock pulse count. The bench's scenarios show these by comparing the whole serial stream against a model built from the records. The scenarios cover both modes, all-empty and all-hit columns, garbage in empty records, and mode changes in the middle of a frame.

// File: rtl/colro_pkg.sv
package colro_pkg;
  localparam int REC_W   = 22;
  localparam int TIME_W  = 8;
  localparam int NRG_W   = 5;
  localparam int SUBPX_W = 8;

  typedef struct packed {
    logic               hit;
    logic [TIME_W-1:0]  arrival;
    logic [NRG_W-1:0]   energy;
    logic [SUBPX_W-1:0] subpx;
  } chan_rec_t;

  // number of bits one channel places on the chain
  function automatic int chan_bits(input logic hit, input logic comp);
    return (comp && !hit) ? 1 : REC_W;
  endfunction
endpackage

// File: rtl/colro_cell.sv
module colro_cell
  import colro_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             bypass_i,
  input  logic [REC_W-1:0] rec_i,
  input  logic             sin_i,
  output logic             sout_o
);
  logic [REC_W-1:0] sr_q;
  logic             bypass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      bypass_q <= 1'b0;
    end else if (load_i) begin
      sr_q     <= rec_i;
      bypass_q <= bypass_i;
    end else if (shift_i) begin
      if (bypass_q) sr_q[REC_W-1] <= sin_i;
      else          sr_q          <= {sr_q[REC_W-2:0], sin_i};
    end
  end

  assign sout_o = sr_q[REC_W-1];

  // R5
  skip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_q && shift_i && !load_i) |=> $stable(sr_q[REC_W-2:0]));
endmodule

// File: rtl/colro_ctrl.sv
module colro_ctrl
  import colro_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int NCOL = 4,
  localparam int CIW = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int CW  = $clog2(NCH*REC_W)
)(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            comp_en_i,
  input  logic [NCH-1:0]  ld_hits_i,
  output logic            load_o,
  output logic            shift_o,
  output logic [CIW-1:0]  ld_col_o,
  output logic            ld_comp_o,
  output logic            frame_o,
  output logic [NCOL-1:0] col_sel_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e           st_q;
  logic [CIW-1:0] col_q;
  logic [CW-1:0]  cnt_q;
  logic           comp_q;
  logic           last_bit, last_col, running;
  logic [CW-1:0]  ld_cnt;

  function automatic int col_bits(input logic [NCH-1:0] hits, input logic comp);
    int s;
    s = 0;
    for (int k = 0; k < NCH; k++) s += chan_bits(hits[k], comp);
    return s;
  endfunction

  assign running   = (st_q == ST_RUN);
  assign last_bit  = running && (cnt_q == '0);
  assign last_col  = (col_q == CIW'(NCOL-1));
  assign load_o    = (!running && start_i) || (last_bit && !last_col);
  assign shift_o   = running && !load_o;
  assign ld_col_o  = running ? CIW'(col_q + 1'b1) : '0;
  assign ld_comp_o = running ? comp_q : comp_en_i;
  assign ld_cnt    = CW'(col_bits(ld_hits_i, ld_comp_o) - 1);
  assign frame_o   = running;

  always_comb begin
    col_sel_o = '0;
    if (running) col_sel_o[col_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      col_q  <= '0;
      cnt_q  <= '0;
      comp_q <= 1'b0;
    end else if (!running) begin
      if (start_i) begin
        st_q   <= ST_RUN;
        col_q  <= '0;
        cnt_q  <= ld_cnt;
        comp_q <= comp_en_i;
      end
    end else if (last_bit) begin
      if (last_col) st_q <= ST_IDLE;
      else begin
        col_q <= ld_col_o;
        cnt_q <= ld_cnt;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_o && start_i) |=> frame_o);
  // R6
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && !last_bit) |=> (col_sel_o == $past(col_sel_o)));
  // R7
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_o) |-> ($past(last_col) && $past(cnt_q) == '0));
  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && !last_bit) |=> (frame_o && $stable(comp_q)));
  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (int'(cnt_q) < NCH*REC_W));
endmodule

// File: rtl/colro_chain_top.sv
module colro_chain_top
  import colro_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int NCOL = 4,
  localparam int CIW = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int COL_W = NCH*REC_W
)(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   comp_en_i,
  input  logic [NCOL*COL_W-1:0]  rec_i,
  output logic                   sdo_o,
  output logic                   frame_o,
  output logic                   smp_clk_o,
  output logic [NCOL-1:0]        col_sel_o
);
  logic             load, shift, ld_comp;
  logic [CIW-1:0]   ld_col;
  logic [COL_W-1:0] col_data;
  logic [NCH-1:0]   ld_hits;
  logic [NCH:0]     link;

  assign col_data = rec_i[int'(ld_col)*COL_W +: COL_W];

  colro_ctrl #(.NCH(NCH), .NCOL(NCOL)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .comp_en_i,
    .ld_hits_i(ld_hits), .load_o(load), .shift_o(shift),
    .ld_col_o(ld_col), .ld_comp_o(ld_comp),
    .frame_o, .col_sel_o
  );

  assign link[NCH] = 1'b0;

  for (genvar g = 0; g < NCH; g++) begin : g_cell
    chan_rec_t r;
    assign r          = chan_rec_t'(col_data[g*REC_W +: REC_W]);
    assign ld_hits[g] = r.hit;
    colro_cell u_cell (
      .clk_i, .rst_ni, .load_i(load), .shift_i(shift),
      .bypass_i(ld_comp && !r.hit), .rec_i(col_data[g*REC_W +: REC_W]),
      .sin_i(link[g+1]), .sout_o(link[g])
    );
  end

  assign sdo_o     = frame_o & link[0];
  assign smp_clk_o = frame_o & ~clk_i;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_o |-> (!sdo_o && col_sel_o == '0));
endmodule

// File: tb/test_colro_chain_top.sv
module test_colro_chain_top;
  localparam int NCH  = 16;
  localparam int NCOL = 4;
  localparam int RW   = 22;
  localparam int MAXB = NCOL*NCH*RW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic comp_en = 1'b0;
  logic [MAXB-1:0] rec = '0;
  logic sdo, frame, smp_clk;
  logic [NCOL-1:0] col_sel;

  int errors = 0, checks = 0, pulses = 0, cycles = 0;
  logic exp_bit [MAXB];
  int   exp_col [MAXB];
  int   exp_len;

  always #2.5 clk = ~clk;

  colro_chain_top #(.NCH(NCH), .NCOL(NCOL)) i_colro_chain_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .comp_en_i(comp_en),
    .rec_i(rec), .sdo_o(sdo), .frame_o(frame), .smp_clk_o(smp_clk),
    .col_sel_o(col_sel)
  );

  always @(posedge smp_clk) pulses++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected stream: flag first, then fields MSB first; empty channels give one 0 when compressing
  task automatic build(input bit comp);
    exp_len = 0;
    for (int c = 0; c < NCOL; c++)
      for (int ch = 0; ch < NCH; ch++) begin
        logic [RW-1:0] r;
        r = rec[(c*NCH+ch)*RW +: RW];
        if (comp && !r[RW-1]) begin
          exp_bit[exp_len] = 1'b0; exp_col[exp_len] = c; exp_len++;
        end else
          for (int b = RW-1; b >= 0; b--) begin
            exp_bit[exp_len] = r[b]; exp_col[exp_len] = c; exp_len++;
          end
      end
  endtask

  task automatic fill(input int hit_pct, input bit garbage);
    for (int k = 0; k < NCOL*NCH; k++) begin
      logic [RW-1:0] r;
      r = RW'($urandom);
      r[RW-1] = ($urandom % 100) < hit_pct;
      if (!r[RW-1] && !garbage) r = '0;
      rec[k*RW +: RW] = r;
    end
  endtask

  task automatic run_frame(input bit comp, input bit disturb, input string tag);
    int n = 0, bad_bits = 0, bad_col = 0, first = -1;
    build(comp);
    comp_en = comp;
    pulses = 0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    forever begin
      @(negedge clk);
      if (!frame || n > MAXB + 4) break;
      if (n == 0) first = sdo;
      if (n < exp_len) begin
        if (sdo !== exp_bit[n]) bad_bits++;
        if (col_sel !== (NCOL'(1) << exp_col[n])) bad_col++;
      end
      if (disturb && n == 7)  begin comp_en = ~comp; start = 1'b1; end
      if (disturb && n == 9)  start = 1'b0;
      n++;
    end
    start = 1'b0;
    check(first == int'(exp_bit[0]), "R2 first bit is ch0 flag", first, exp_bit[0]);
    check(n == exp_len, {tag, " R7 frame length"}, n, exp_len);
    check(bad_bits == 0, "R3 bit order/content mismatches", bad_bits, 0);
    check(bad_col == 0, "R6 column select mismatches", bad_col, 0);
    check(pulses == exp_len, "R8 sample clock pulses", pulses, exp_len);
    @(negedge clk);
    check(!frame && !sdo && col_sel == '0, "R1 idle after frame",
          int'({frame, sdo, col_sel}), 0);
    comp_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    #1;
    check(!frame && !sdo && col_sel == '0 && !smp_clk, "R1 reset state",
          int'({frame, sdo, col_sel}), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!frame && pulses == 0, "R1 idle with no request", pulses, 0);

    // R4: full mode, garbage in empty records is still sent
    fill(30, 1'b1);
    run_frame(1'b0, 1'b0, "R4 full");
    check(exp_len == MAXB, "R4 full length equals NCOL*NCH*22", exp_len, MAXB);
    // R5: compressed, random occupancy with garbage in empty channels
    fill(20, 1'b1);
    run_frame(1'b1, 1'b0, "R5 compressed");
    // R5: all channels empty -> one bit each
    fill(0, 1'b1);
    run_frame(1'b1, 1'b0, "R5 all empty");
    check(exp_len == NCOL*NCH, "R5 all-empty length", exp_len, NCOL*NCH);
    // R5: all channels hit -> same as full mode
    fill(100, 1'b0);
    run_frame(1'b1, 1'b0, "R5 all hit");
    // R9: mode toggled and start repeated mid-frame
    fill(40, 1'b1);
    run_frame(1'b1, 1'b1, "R9 compressed disturbed");
    fill(40, 1'b1);
    run_frame(1'b0, 1'b1, "R9 full disturbed");
    // R3: directed pattern, single hit in last channel of last column
    rec = '0;
    rec[(NCOL*NCH-1)*RW +: RW] = {1'b1, 8'hA5, 5'h13, 8'h3C};
    run_frame(1'b1, 1'b0, "R3 directed");
    check(exp_len == NCOL*NCH - 1 + RW, "R5 directed length", exp_len, NCOL*NCH - 1 + RW);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule